// File: doc/BRIEF.md
# First-Fault Gather Load Sequencer

This block carries out one vector gather load with first-fault semantics. A start pulse captures a 256-bit base-address vector, a byte-granular predicate, a 5-bit immediate, a lane-width select, the old destination vector, the incoming first-fault mask and an unknown-lane data policy. The block then steps through the lanes in increasing order. For each active lane it issues one 32-bit word read on a valid/ready request channel and waits for the answer on a valid/ready response channel. The response carries a fault flag.

Only the first active lane's access may take a real fault. If that access faults, the operation is abandoned. The block then reports the fault and hands back the old destination and the incoming mask unchanged. Every later access is marked non-faulting. A fault on one of those accesses only clears mask bits, from that lane upward. After the walk, a one-cycle done pulse presents the result vector, the updated mask and the first-lane fault flag. These outputs hold until the next operation starts.

Back-pressure rules: the request holds `mem_req_valid`, `mem_req_addr` and `mem_req_nf` stable until `mem_req_ready` is seen. Only one request is outstanding at a time. `mem_rsp_ready` is high only while an answer is awaited, and an answer is taken in the cycle where `mem_rsp_valid` and `mem_rsp_ready` are both high.

Top module: `ffg_seq`

## Requirements
- R1: Lane address = lane base value zero-extended to 64 bits, plus `imm5` times 4 (byte offset 0..124), modulo 2^64.
- R2: The 32-bit word read for a lane is zero-extended to the lane width before it is placed in the lane.
- R3: An inactive lane issues no request. Outside the unknown region its result is zero. A lane is active when predicate bit `lane*4` (32-bit lanes) or `lane*8` (64-bit lanes) is 1.
- R4: Lanes are visited in increasing order with at most one request outstanding. A stalled request keeps its valid and address stable.
- R5: If the first active lane's access faults, done follows in the next cycle with `fault_first`=1, `result` = old destination, `ffr_out` = incoming mask, and no further requests are made.
- R6: `mem_req_nf` is 0 for the first active lane's request and 1 for every later request.
- R7: A fault on a non-first access is sticky. All mask bits of that lane and of every higher lane are cleared, lower lanes keep their bits, and the remaining active lanes are still read.
- R8: The unknown region starts at the first lane whose mask bit (at `lane*4` or `lane*8`, taken after fault clearing) is 0, and it extends to all higher lanes. In that region `unk_pol` picks the lane value: 0 = loaded data if that access did not fault (otherwise the old lane), 1 = zero, 2 or 3 = the old lane.
- R9: With no active lane, no request is made. Done follows one cycle after start with `result`=0, `ffr_out` = incoming mask and `fault_first`=0.
- R10: `wide`=0 gives eight 32-bit lanes and `wide`=1 gives four 64-bit lanes.
- R11: A start that arrives while `busy` is high is ignored.
- R12: `done` is a one-cycle pulse. `result`, `ffr_out` and `fault_first` hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| wide | input | 1 | 0: 32-bit lanes, 1: 64-bit lanes |
| pred | input | 32 | Predicate, one bit per byte |
| imm5 | input | 5 | Immediate, scaled by 4 |
| base_vec | input | 256 | Base addresses per lane |
| old_vec | input | 256 | Old destination vector |
| ffr_in | input | 32 | Incoming first-fault mask, one bit per byte |
| unk_pol | input | 2 | Unknown-lane data policy |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result valid pulse |
| fault_first | output | 1 | First active access faulted |
| result | output | 256 | Destination vector |
| ffr_out | output | 32 | Updated first-fault mask |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 64 | Read byte address |
| mem_req_nf | output | 1 | Request is non-faulting |
| mem_rsp_valid | input | 1 | Response valid |
| mem_rsp_ready | output | 1 | Block waits for a response |
| mem_rsp_data | input | 32 | Read word |
| mem_rsp_fault | input | 1 | Access faulted |

## Verification
The bench aims faults at the first active lane and at a middle lane. A design that marks the wrong access non-faulting would update registers on a real fault, or would abort on a suppressed one. It walks a 32-bit base close to 2^32 with the largest offset, which a design that truncates or sign-extends would wrap to a low address. It runs the three unknown-lane policies against a pre-cleared mask bit and an active lane after a fault: a design with wrong sticky propagation leaks loaded data into lanes that should be zero or merged. It also covers an empty predicate and a start arriving mid-operation, where a design would issue stray reads or produce a second done.

// File: rtl/ffg_pkg.sv
package ffg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_FIN   = 2'd3
  } ffg_state_e;

  localparam logic [1:0] POL_DATA = 2'd0;
  localparam logic [1:0] POL_ZERO = 2'd1;
endpackage

// File: rtl/ffg_lane_tap.sv
// Extracts one lane of a vector, zero-extended to 64 bits.
module ffg_lane_tap #(
  parameter int VLEN = 256,
  localparam int NLMAX = VLEN / 32,
  localparam int IW = $clog2(NLMAX)
) (
  input  logic [VLEN-1:0] vec,
  input  logic [IW-1:0]   lane,
  input  logic            wide,
  output logic [63:0]     val
);
  logic [IW-2:0] lane_w;
  assign lane_w = lane[IW-2:0];

  always_comb begin
    if (wide) val = vec[32'(lane_w) * 64 +: 64];
    else      val = {32'b0, vec[32'(lane) * 32 +: 32]};
  end
endmodule

// File: rtl/ffg_lane_pick.sv
// Chooses the value written into a lane once the lane's access is done.
module ffg_lane_pick
  import ffg_pkg::*;
#(
  parameter int WW = 32
) (
  input  logic          unk,
  input  logic          flt,
  input  logic [1:0]    pol,
  input  logic [WW-1:0] data,
  input  logic [63:0]   old_lane,
  output logic [63:0]   val
);
  logic [63:0] loaded;
  assign loaded = 64'(data);

  always_comb begin
    if (!unk)                       val = loaded;
    else if (pol == POL_DATA)       val = flt ? old_lane : loaded;
    else if (pol == POL_ZERO)       val = '0;
    else                            val = old_lane;
  end
endmodule

// File: rtl/ffg_seq.sv
module ffg_seq
  import ffg_pkg::*;
#(
  parameter int VLEN = 256,
  parameter int AW   = 64,
  parameter int WW   = 32,
  localparam int PL    = VLEN / 8,
  localparam int NLMAX = VLEN / 32,
  localparam int IW    = $clog2(NLMAX)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            wide,
  input  logic [PL-1:0]   pred,
  input  logic [4:0]      imm5,
  input  logic [VLEN-1:0] base_vec,
  input  logic [VLEN-1:0] old_vec,
  input  logic [PL-1:0]   ffr_in,
  input  logic [1:0]      unk_pol,
  output logic            busy,
  output logic            done,
  output logic            fault_first,
  output logic [VLEN-1:0] result,
  output logic [PL-1:0]   ffr_out,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [AW-1:0]   mem_req_addr,
  output logic            mem_req_nf,
  input  logic            mem_rsp_valid,
  output logic            mem_rsp_ready,
  input  logic [WW-1:0]   mem_rsp_data,
  input  logic            mem_rsp_fault
);
  ffg_state_e      st_q;
  logic [IW-1:0]   lane_q;
  logic            wide_q, first_q, faulted_q, unk_q, ff_q;
  logic [PL-1:0]   pred_q, ffr0_q, ffr_q;
  logic [4:0]      imm_q;
  logic [1:0]      pol_q;
  logic [VLEN-1:0] base_q, old_q, res_q;

  logic [63:0]     base_lane, old_lane, lane_val;
  logic            act, any_act, lane_end, last_lane, abort;
  logic            flt_eff, fl_n, ubit, unk_n;
  logic [WW-1:0]   data_eff;
  logic [PL-1:0]   ffr_n;
  logic [IW-1:0]   lane_w;
  int              lbit;

  ffg_lane_tap #(.VLEN(VLEN)) u_tap_base (
    .vec(base_q), .lane(lane_q), .wide(wide_q), .val(base_lane));
  ffg_lane_tap #(.VLEN(VLEN)) u_tap_old (
    .vec(old_q), .lane(lane_q), .wide(wide_q), .val(old_lane));

  // Any active lane in the incoming predicate
  always_comb begin
    any_act = 1'b0;
    for (int e = 0; e < NLMAX; e++) begin
      if (!wide && pred[(e * 4) % PL]) any_act = 1'b1;
      if (wide && e < NLMAX / 2 && pred[(e * 8) % PL]) any_act = 1'b1;
    end
  end

  assign lane_w    = wide_q ? {1'b0, lane_q[IW-2:0]} : lane_q;
  assign lbit      = wide_q ? 32'(lane_w) * 8 : 32'(lane_w) * 4;
  assign act       = pred_q[lbit];
  assign last_lane = wide_q ? (lane_q == IW'(NLMAX / 2 - 1)) : (lane_q == IW'(NLMAX - 1));

  assign mem_req_valid = (st_q == ST_ISSUE) && act;
  assign mem_req_addr  = AW'(base_lane) + AW'({imm_q, 2'b00});
  assign mem_req_nf    = !first_q;
  assign mem_rsp_ready = (st_q == ST_WAIT);

  assign abort    = mem_rsp_valid && mem_rsp_ready && mem_rsp_fault && first_q;
  assign lane_end = ((st_q == ST_ISSUE) && !act) ||
                    (mem_rsp_valid && mem_rsp_ready && !abort);
  assign flt_eff  = act && mem_rsp_fault;
  assign data_eff = act ? mem_rsp_data : '0;
  assign fl_n     = faulted_q || flt_eff;

  // Mask clearing for the current lane once the sticky fault is set
  always_comb begin
    ffr_n = ffr_q;
    for (int b = 0; b < PL; b++) begin
      if (fl_n && ((wide_q ? b / 8 : b / 4) == 32'(lane_w))) ffr_n[b] = 1'b0;
    end
  end
  assign ubit  = ffr_n[lbit];
  assign unk_n = unk_q || !ubit;

  ffg_lane_pick #(.WW(WW)) u_pick (
    .unk(unk_n), .flt(flt_eff), .pol(pol_q), .data(data_eff),
    .old_lane(old_lane), .val(lane_val));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;   lane_q <= '0;   wide_q <= 1'b0; first_q <= 1'b0;
      faulted_q <= 1'b0; unk_q <= 1'b0;  ff_q <= 1'b0;   pred_q <= '0;
      ffr0_q <= '0;      ffr_q <= '0;    imm_q <= '0;    pol_q <= '0;
      base_q <= '0;      old_q <= '0;    res_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) begin
          wide_q <= wide;  pred_q <= pred;  imm_q <= imm5;  pol_q <= unk_pol;
          base_q <= base_vec;  old_q <= old_vec;  ffr0_q <= ffr_in;  ffr_q <= ffr_in;
          res_q <= '0;  ff_q <= 1'b0;  lane_q <= '0;
          first_q <= 1'b1;  faulted_q <= 1'b0;  unk_q <= 1'b0;
          st_q <= any_act ? ST_ISSUE : ST_FIN;
        end
        ST_ISSUE: if (act && mem_req_ready) st_q <= ST_WAIT;
        ST_WAIT: if (abort) begin
          ff_q <= 1'b1;  res_q <= old_q;  ffr_q <= ffr0_q;  st_q <= ST_FIN;
        end
        ST_FIN: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
      if (lane_end) begin
        if (act) first_q <= 1'b0;
        faulted_q <= fl_n;
        unk_q     <= unk_n;
        ffr_q     <= ffr_n;
        if (wide_q) res_q[32'(lane_w) * 64 +: 64] <= lane_val;
        else        res_q[32'(lane_w) * 32 +: 32] <= lane_val[31:0];
        lane_q <= lane_q + 1'b1;
        st_q   <= last_lane ? ST_FIN : ST_ISSUE;
      end
    end
  end

  assign busy        = (st_q != ST_IDLE);
  assign done        = (st_q == ST_FIN);
  assign fault_first = ff_q;
  assign result      = res_q;
  assign ffr_out     = ffr_q;
endmodule

// File: rtl/ffg_seq_chk.sv
module ffg_seq_chk #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          fault_first,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          mem_req_nf,
  input logic          mem_rsp_valid,
  input logic          mem_rsp_ready,
  input logic          mem_rsp_fault
);
  logic seen_req, nf_hs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_req <= 1'b0;
      nf_hs    <= 1'b0;
    end else begin
      if (start && !busy) seen_req <= 1'b0;
      else if (mem_req_valid && mem_req_ready) seen_req <= 1'b1;
      if (mem_req_valid && mem_req_ready) nf_hs <= mem_req_nf;
    end
  end

  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r4_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_ready |-> !mem_req_valid);

  a_r6_nf_mark: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_nf == seen_req));

  a_r5_first_abort: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid && mem_rsp_ready && mem_rsp_fault && !nf_hs |=> done && fault_first);

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy && !done |=> busy);
endmodule

bind ffg_seq ffg_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_ffg_seq.sv
module sim_ffg_seq;
  localparam int VLEN = 256;
  localparam int PL = VLEN / 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wide = 1'b0;
  logic [PL-1:0] pred = '0, ffr_in = '0;
  logic [4:0] imm5 = '0;
  logic [VLEN-1:0] base_vec = '0, old_vec = '0;
  logic [1:0] unk_pol = '0;
  logic busy, done, fault_first, mem_req_valid, mem_req_nf, mem_rsp_ready;
  logic [VLEN-1:0] result;
  logic [PL-1:0] ffr_out;
  logic [63:0] mem_req_addr;
  logic mem_req_ready = 1'b0, mem_rsp_valid = 1'b0, mem_rsp_fault = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  always #4 clk = ~clk;

  ffg_seq u0 (.*);

  typedef struct { logic [VLEN-1:0] res; logic [PL-1:0] ffr; logic ff; string tag; } exp_t;
  typedef struct { logic [63:0] addr; logic nf; } req_t;
  exp_t exp_q[$];
  req_t req_q[$];

  int total = 0, bad = 0, hs_cnt = 0;
  logic [63:0] flt_a = '1, flt_b = '1;

  function automatic logic [31:0] mdata(logic [63:0] a);
    return a[31:0] ^ 32'h5A5A_0F0F;
  endfunction
  function automatic logic is_flt(logic [63:0] a);
    return (a == flt_a) || (a == flt_b);
  endfunction

  task automatic check(string tag, logic [VLEN-1:0] got, logic [VLEN-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Independent model: pushes expected requests and the expected outcome.
  task automatic model(string tag);
    int n = wide ? 4 : 8, eb = wide ? 8 : 4;
    logic any = 1'b0, first = 1'b1, fltd = 1'b0, unk = 1'b0, f, ff = 1'b0;
    logic [PL-1:0] fr = ffr_in;
    logic [VLEN-1:0] r = '0;
    logic [63:0] a, d, ol, v;
    exp_t x;
    for (int e = 0; e < n; e++) if (pred[e*eb]) any = 1'b1;
    if (any) begin
      for (int e = 0; e < n; e++) begin
        d = '0; f = 1'b0;
        ol = wide ? old_vec[e*64 +: 64] : {32'b0, old_vec[e*32 +: 32]};
        if (pred[e*eb]) begin
          a = (wide ? base_vec[e*64 +: 64] : {32'b0, base_vec[e*32 +: 32]}) + {57'b0, imm5, 2'b00};
          req_q.push_back('{addr: a, nf: !first});
          f = is_flt(a); d = {32'b0, mdata(a)};
          if (first && f) begin ff = 1'b1; break; end
          first = 1'b0;
        end
        fltd = fltd | f;
        if (fltd) for (int b = 0; b < eb; b++) fr[e*eb + b] = 1'b0;
        unk = unk | !fr[e*eb];
        if (!unk) v = d;
        else if (unk_pol == 2'd0) v = f ? ol : d;
        else if (unk_pol == 2'd1) v = '0;
        else v = ol;
        if (wide) r[e*64 +: 64] = v; else r[e*32 +: 32] = v[31:0];
      end
    end
    if (ff) begin r = old_vec; fr = ffr_in; end
    x.res = r; x.ffr = fr; x.ff = ff; x.tag = tag;
    exp_q.push_back(x);
  endtask

  // Memory model: stall pattern on ready, variable response latency.
  int mcyc = 0, lat = 0;
  logic hs_pend = 1'b0;
  logic [63:0] hs_addr;
  logic hs_nf;
  always @(negedge clk) begin
    mcyc++;
    if (mem_rsp_valid) mem_rsp_valid = 1'b0;
    if (hs_pend) begin
      req_t q;
      hs_pend = 1'b0; hs_cnt++;
      if (req_q.size() == 0) check("R3/R9 unexpected request", {192'b0, hs_addr}, '1);
      else begin
        q = req_q.pop_front();
        check("R1/R4 request address", {192'b0, hs_addr}, {192'b0, q.addr});
        check("R6 non-faulting mark", {255'b0, hs_nf}, {255'b0, q.nf});
      end
      lat = 1 + (mcyc % 3);
      mem_rsp_data = mdata(hs_addr);
      mem_rsp_fault = is_flt(hs_addr);
    end
    if (lat > 0) begin
      lat--;
      if (lat == 0) mem_rsp_valid = 1'b1;
    end
    mem_req_ready = (mcyc % 4) != 1;
    if (mem_req_valid && mem_req_ready) begin
      hs_pend = 1'b1; hs_addr = mem_req_addr; hs_nf = mem_req_nf;
    end
  end

  // Scoreboard monitor
  int done_cnt = 0;
  always @(negedge clk) begin
    if (rst_n && done) begin
      exp_t x;
      done_cnt++;
      if (exp_q.size() == 0) check("R11 unexpected done", 256'd1, 256'd0);
      else begin
        x = exp_q.pop_front();
        check({x.tag, " result"}, result, x.res);
        check({x.tag, " ffr R7"}, {224'b0, ffr_out}, {224'b0, x.ffr});
        check({x.tag, " fault_first R5"}, {255'b0, fault_first}, {255'b0, x.ff});
      end
    end
  end

  task automatic run(string tag);
    logic [VLEN-1:0] r;
    @(negedge clk);
    model(tag);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    r = result;
    @(negedge clk);
    check({tag, " R12 done pulse"}, {255'b0, done}, 256'd0);
    check({tag, " R12 result held"}, result, r);
  endtask

  function automatic logic [VLEN-1:0] mk_base32(logic [31:0] b0);
    logic [VLEN-1:0] v;
    for (int e = 0; e < 8; e++) v[e*32 +: 32] = b0 + 32'(e * 32'h40);
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int h0, d0;
    repeat (3) @(negedge clk);
    check("reset busy/done/req", {253'b0, busy, done, mem_req_valid}, 256'd0);
    check("reset result", result, 256'd0);
    rst_n = 1'b1;
    old_vec = {8{32'hFFFF_FFFF}};

    // R1 R2 R10: 32-bit lanes, all active, clean mask
    wide = 1'b0; pred = '1; ffr_in = '1; imm5 = 5'd5; unk_pol = 2'd0;
    base_vec = mk_base32(32'h0000_1000);
    run("R1 R2 R10 narrow all active");

    // R1 R3: large 32-bit base plus max offset, mixed predicate
    base_vec = mk_base32(32'hFFFF_FF40); imm5 = 5'd31;
    pred = 32'h0F0F_0F00 & 32'h1111_1111 | 32'h0000_1010;
    run("R1 R3 offset 124 no wrap");

    // R2 R10: 64-bit lanes, zero-extension of loaded word
    wide = 1'b1; pred = 32'h0100_0101; imm5 = 5'd2;
    base_vec = {64'h0000_00AB_0000_3000, 64'h0000_0001_0000_2000,
                64'h1234_5678_0000_1000, 64'h0000_0000_0000_0800};
    run("R2 R10 wide lanes");

    // R5: fault on first active lane (lane 1)
    wide = 1'b0; pred = 32'hFFFF_FFF0; imm5 = 5'd0; unk_pol = 2'd1;
    base_vec = mk_base32(32'h0000_2000);
    flt_a = 64'h0000_2040;
    run("R5 first lane fault");

    // R7 R8: suppressed fault on lane 3, each policy
    pred = '1; flt_a = 64'h0000_20C0;
    for (int p = 0; p < 3; p++) begin
      unk_pol = 2'(p);
      run($sformatf("R7 R8 mid fault pol%0d", p));
    end

    // R8: mask bit already clear at lane 2, merge policy, with inactive lane 5
    flt_a = '1; ffr_in = 32'hFFFF_F0FF; pred = 32'hFF0F_FFFF; unk_pol = 2'd2;
    run("R8 preclear merge");
    unk_pol = 2'd0;
    run("R8 preclear data");

    // R7 R10: wide lanes, fault on lane 2 after lane 0 ok
    wide = 1'b1; pred = 32'h0101_0101; ffr_in = '1; unk_pol = 2'd0;
    base_vec = {64'h4000, 64'h3000, 64'h2000, 64'h1000};
    flt_a = 64'h3000; flt_b = 64'h4000;
    run("R7 R10 wide mid fault");
    flt_a = '1; flt_b = '1;

    // R9: no active lane, only odd predicate bits set
    wide = 1'b0; pred = 32'h2222_2222; ffr_in = 32'h1234_5678;
    h0 = hs_cnt;
    run("R9 empty predicate");
    check("R9 no requests", 256'(hs_cnt), 256'(h0));

    // R11: second start mid-run ignored
    pred = '1; ffr_in = '1; base_vec = mk_base32(32'h0000_5000);
    d0 = done_cnt;
    @(negedge clk);
    model("R11 first op");
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    base_vec = mk_base32(32'h0000_9000); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (80) @(negedge clk);
    check("R11 one done only", 256'(done_cnt - d0), 256'd1);
    check("R11 idle after", {255'b0, busy}, 256'd0);
    check("R3/R9 request queue drained", 256'(req_q.size()), 256'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule